// File: doc/BRIEF.md
# Transmit buffer request and cancellation tracker

This block keeps the transmit bookkeeping for a small set of dedicated message buffers in a CAN-style controller. Software posts new transmit requests and cancellations as bit masks, one bit per buffer. The block picks the next buffer to hand to a transmitter engine. It then follows that transmission to its end and keeps three status vectors per buffer: request pending, transmission occurred and cancellation finished.

A cancellation can reach a buffer that is still waiting or one that is already on the bus. A waiting buffer is withdrawn at once. For a buffer already on the bus, the cancellation is held until the engine reports the end of that transmission. The outcome then decides which status bits are set. A failed transmission with no cancellation pending stays queued, so the buffer is retried. Among the waiting buffers, the one with the lowest message identifier goes first.

Top module: `txc_ctrl`

## Requirements
- R1: A 1 in bit n of `add_req` on a buffer that is not being transmitted sets pending[n] and clears occurred[n] and cancel-finished[n] at the next clock edge. On a buffer that is being transmitted it has no effect.
- R2: A 1 in bit n of `cxl_req` on a buffer that is pending but not started clears pending[n] and sets cancel-finished[n] at the next edge. Bits written as 0, and cancels of buffers that are not pending, have no effect.
- R3: `tx_start` is high in a cycle in which `tx_ready` is high, no transmission is in progress and at least one eligible buffer exists. An eligible buffer is pending, not started and not being cancelled in that cycle. `tx_start_idx` is the eligible buffer with the lowest identifier, and ties go to the lowest index.
- R4: Only one transmission is in progress at a time. No start is issued between a start and the cycle after its done strobe.
- R5: A done strobe with `tx_ok`=1 and no cancel pending clears pending[n] and sets occurred[n] of the active buffer at the next edge.
- R6: A done strobe with `tx_ok`=0 and no cancel pending leaves pending[n] set, so the buffer is started again.
- R7: A cancel of the buffer being transmitted leaves pending[n] set until the done strobe.
- R8: If a cancel was held for the active buffer and the transmission succeeds, pending[n] clears and both occurred[n] and cancel-finished[n] are set.
- R9: If a cancel was held for the active buffer and the transmission fails, pending[n] clears and only cancel-finished[n] is set. The buffer is not retried.
- R10: If `add_req` and `cxl_req` hit the same idle buffer in the same cycle, the add takes effect and the cancel is dropped.
- R11: After reset, all three status vectors are zero and `tx_start` stays low.
- R12: A done strobe while no transmission is in progress changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| add_req | input | NBUF | One-cycle mask of new transmit requests |
| cxl_req | input | NBUF | One-cycle mask of cancellation requests |
| buf_ids | input | NBUF*IDW | Message identifier of each buffer, buffer 0 in the low bits |
| tx_ready | input | 1 | Transmitter engine can accept a start |
| tx_start | output | 1 | One-cycle start strobe |
| tx_start_idx | output | IDXW | Buffer index carried with the start strobe |
| tx_done | input | 1 | One-cycle end-of-transmission strobe |
| tx_ok | input | 1 | Transmission succeeded, valid with `tx_done` |
| pend_vec | output | NBUF | Request-pending status per buffer |
| sent_vec | output | NBUF | Transmission-occurred status per buffer |
| cfin_vec | output | NBUF | Cancellation-finished status per buffer |

## Verification
The hardest case to reach from the ports is a cancel that lands on the buffer the engine is currently sending. The stimulus has to post requests, let the selector start the chosen buffer, and write the cancel in the cycles between start and done. Only then does it strobe done with success or failure. The stimulus table runs this sequence once with a failing end and once with a succeeding end. It checks that pending stays set through the held window. The same table also cancels an idle buffer in the very cycle the selector would otherwise pick it, so the start falls through to the next identifier.

// File: rtl/txc_pkg.sv
package txc_pkg;
    localparam int NUM_BUF = 4;
    localparam int ID_W    = 11;

    typedef struct packed {
        logic pend;   // request waiting or on the bus
        logic act;    // currently handed to the engine
        logic defer;  // cancel held until done
        logic sent;   // transmission occurred
        logic cfin;   // cancellation finished
    } slot_t;

    function automatic slot_t slot_next(input slot_t s, input logic add, input logic cxl,
                                        input logic start, input logic done, input logic ok);
        slot_t n;
        n = s;
        if (done) begin
            n.act = 1'b0;
            if (ok) begin
                n.sent = 1'b1;
                n.pend = 1'b0;
            end
            if (s.defer || cxl) begin
                n.cfin = 1'b1;
                n.pend = 1'b0;
            end
            n.defer = 1'b0;
        end else if (cxl && s.act) begin
            n.defer = 1'b1;
        end else if (cxl && s.pend) begin
            n.pend = 1'b0;
            n.cfin = 1'b1;
        end
        if (start) n.act = 1'b1;
        if (add && !s.act) begin
            n.pend = 1'b1;
            n.sent = 1'b0;
            n.cfin = 1'b0;
        end
        return n;
    endfunction
endpackage

// File: rtl/txc_slot.sv
module txc_slot
    import txc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  add_i,
    input  logic  cxl_i,
    input  logic  start_i,
    input  logic  done_i,
    input  logic  ok_i,
    output slot_t st_o
);
    slot_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= slot_next(st_q, add_i, cxl_i, start_i, done_i, ok_i);
    end

    assign st_o = st_q;
endmodule

// File: rtl/txc_pick.sv
module txc_pick #(
    parameter int NBUF = 4,
    parameter int IDW  = 11,
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [NBUF-1:0]     cand,
    input  logic [NBUF*IDW-1:0] ids,
    output logic                any_o,
    output logic [IDXW-1:0]     idx_o
);
    logic [IDW-1:0] best_id;

    always_comb begin
        any_o   = 1'b0;
        idx_o   = '0;
        best_id = '1;
        for (int i = 0; i < NBUF; i++) begin
            if (cand[i] && (!any_o || ids[i*IDW +: IDW] < best_id)) begin
                any_o   = 1'b1;
                idx_o   = IDXW'(i);
                best_id = ids[i*IDW +: IDW];
            end
        end
    end
endmodule

// File: rtl/txc_ctrl.sv
module txc_ctrl
    import txc_pkg::*;
#(
    parameter int NBUF = NUM_BUF,
    parameter int IDW  = ID_W,
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NBUF-1:0]     add_req,
    input  logic [NBUF-1:0]     cxl_req,
    input  logic [NBUF*IDW-1:0] buf_ids,
    input  logic                tx_ready,
    output logic                tx_start,
    output logic [IDXW-1:0]     tx_start_idx,
    input  logic                tx_done,
    input  logic                tx_ok,
    output logic [NBUF-1:0]     pend_vec,
    output logic [NBUF-1:0]     sent_vec,
    output logic [NBUF-1:0]     cfin_vec
);
    slot_t           slots [NBUF];
    logic [NBUF-1:0] act_vec;
    logic [NBUF-1:0] defer_vec;
    logic [NBUF-1:0] cand;
    logic [NBUF-1:0] start_sel;
    logic            any_cand;
    logic            busy;
    logic [IDXW-1:0] pick_idx;

    assign busy     = |act_vec;
    assign cand     = pend_vec & ~act_vec & ~cxl_req;
    assign tx_start = tx_ready && !busy && any_cand;
    assign tx_start_idx = pick_idx;

    txc_pick #(.NBUF(NBUF), .IDW(IDW)) pick_i (
        .cand  (cand),
        .ids   (buf_ids),
        .any_o (any_cand),
        .idx_o (pick_idx)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        assign start_sel[g] = tx_start && (pick_idx == IDXW'(g));

        txc_slot slot_i (
            .clk     (clk),
            .rst     (rst),
            .add_i   (add_req[g]),
            .cxl_i   (cxl_req[g]),
            .start_i (start_sel[g]),
            .done_i  (tx_done && act_vec[g]),
            .ok_i    (tx_ok),
            .st_o    (slots[g])
        );

        assign pend_vec[g]  = slots[g].pend;
        assign sent_vec[g]  = slots[g].sent;
        assign cfin_vec[g]  = slots[g].cfin;
        assign act_vec[g]   = slots[g].act;
        assign defer_vec[g] = slots[g].defer;
    end
endmodule

// File: rtl/txc_ctrl_chk.sv
module txc_ctrl_chk #(
    parameter int NBUF = 4,
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic [NBUF-1:0] add_req,
    input logic [NBUF-1:0] cxl_req,
    input logic            tx_start,
    input logic [IDXW-1:0] tx_start_idx,
    input logic            tx_done,
    input logic            tx_ok,
    input logic [NBUF-1:0] pend_vec,
    input logic [NBUF-1:0] sent_vec,
    input logic [NBUF-1:0] cfin_vec,
    input logic [NBUF-1:0] act_vec,
    input logic [NBUF-1:0] defer_vec
);
    p_start_eligible_r3: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> pend_vec[tx_start_idx] && !cxl_req[tx_start_idx]);

    p_one_active_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_vec));

    p_no_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> act_vec == '0);

    for (genvar n = 0; n < NBUF; n++) begin : g_bit
        p_add_r1: assert property (@(posedge clk) disable iff (rst)
            add_req[n] && !act_vec[n] |=> pend_vec[n] && !sent_vec[n] && !cfin_vec[n]);

        p_cancel_idle_r2: assert property (@(posedge clk) disable iff (rst)
            cxl_req[n] && pend_vec[n] && !act_vec[n] && !add_req[n]
            |=> !pend_vec[n] && cfin_vec[n]);

        p_ok_r5: assert property (@(posedge clk) disable iff (rst)
            tx_done && tx_ok && act_vec[n] |=> sent_vec[n] && !pend_vec[n]);

        p_retry_r6: assert property (@(posedge clk) disable iff (rst)
            tx_done && !tx_ok && act_vec[n] && !defer_vec[n] && !cxl_req[n] |=> pend_vec[n]);

        p_hold_r7: assert property (@(posedge clk) disable iff (rst)
            cxl_req[n] && act_vec[n] && !tx_done |=> pend_vec[n]);

        p_defer_ok_r8: assert property (@(posedge clk) disable iff (rst)
            tx_done && tx_ok && act_vec[n] && defer_vec[n]
            |=> sent_vec[n] && cfin_vec[n] && !pend_vec[n]);

        p_defer_fail_r9: assert property (@(posedge clk) disable iff (rst)
            tx_done && !tx_ok && act_vec[n] && defer_vec[n]
            |=> cfin_vec[n] && !pend_vec[n] && !sent_vec[n]);
    end
endmodule

bind txc_ctrl txc_ctrl_chk #(.NBUF(NBUF)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .add_req      (add_req),
    .cxl_req      (cxl_req),
    .tx_start     (tx_start),
    .tx_start_idx (tx_start_idx),
    .tx_done      (tx_done),
    .tx_ok        (tx_ok),
    .pend_vec     (pend_vec),
    .sent_vec     (sent_vec),
    .cfin_vec     (cfin_vec),
    .act_vec      (act_vec),
    .defer_vec    (defer_vec)
);

// File: tb/txc_ctrl_tb_top.sv
`timescale 1ns/1ps
module txc_ctrl_tb_top;
    localparam int NB = 4;
    localparam int IW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] add_req = '0;
    logic [NB-1:0] cxl_req = '0;
    logic          tx_ready = 1'b0;
    logic          tx_done = 1'b0;
    logic          tx_ok = 1'b0;
    logic          tx_start;
    logic [1:0]    tx_start_idx;
    logic [NB-1:0] pend_vec, sent_vec, cfin_vec;
    // ids: b0=0x120, b1=0x080, b2=0x080, b3=0x200
    logic [NB*IW-1:0] buf_ids = {11'h200, 11'h080, 11'h080, 11'h120};

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    txc_ctrl dut_i (
        .clk(clk), .rst(rst), .add_req(add_req), .cxl_req(cxl_req),
        .buf_ids(buf_ids), .tx_ready(tx_ready), .tx_start(tx_start),
        .tx_start_idx(tx_start_idx), .tx_done(tx_done), .tx_ok(tx_ok),
        .pend_vec(pend_vec), .sent_vec(sent_vec), .cfin_vec(cfin_vec)
    );

    typedef struct packed {
        logic [3:0] add;
        logic [3:0] cxl;
        logic       rdy;
        logic       done;
        logic       ok;
        logic       xs;
        logic [1:0] xi;
        logic [3:0] xp;
        logic [3:0] xsent;
        logic [3:0] xc;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{4'b1111, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b1111, 4'b0000, 4'b0000, 4'd1},  // R1 add all
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 4'b1111, 4'b0000, 4'b0000, 4'd3},  // R3 tie b1/b2 -> b1
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b1111, 4'b0000, 4'b0000, 4'd4},  // R4 busy
        '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 4'b1101, 4'b0010, 4'b0000, 4'd5},  // R5 ok
        '{4'b0000, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'b1001, 4'b0010, 4'b0100, 4'd2},  // R2 + R3 exclusion
        '{4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b1001, 4'b0010, 4'b0100, 4'd7},  // R7 held
        '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'b1000, 4'b0010, 4'b0101, 4'd9},  // R9 fail
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 4'b1000, 4'b0010, 4'b0101, 4'd3},  // R3 start b3
        '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'b1000, 4'b0010, 4'b0101, 4'd6},  // R6 fail kept
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 4'b1000, 4'b0010, 4'b0101, 4'd6},  // R6 retry
        '{4'b0000, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b1000, 4'b0010, 4'b0101, 4'd7},  // R7 held
        '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 4'b0000, 4'b1010, 4'b1101, 4'd8},  // R8 ok
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b1010, 4'b1101, 4'd3},  // R3 none
        '{4'b0001, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0001, 4'b1010, 4'b1100, 4'd1},  // R1 clears cfin
        '{4'b0010, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'b0011, 4'b1000, 4'b1100, 4'd1},  // R1 clears sent
        '{4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0011, 4'b1000, 4'b1100, 4'd1},  // R1 add on active
        '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 4'b0010, 4'b1001, 4'b1100, 4'd5},  // R5 ok
        '{4'b0010, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0010, 4'b1001, 4'b1100, 4'd10}, // R10 add wins
        '{4'b0000, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0010, 4'b1001, 4'b1100, 4'd2},  // R2 not pending
        '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 4'b0010, 4'b1001, 4'b1100, 4'd12}, // R12 stray done
        '{4'b0000, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b1001, 4'b1110, 4'd3}   // R3 cancel beats start
    };

    task automatic chk(input int req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic chk_state(input int req, input logic [3:0] p, input logic [3:0] s, input logic [3:0] c);
        chk(req, "pending", int'(pend_vec), int'(p));
        chk(req, "occurred", int'(sent_vec), int'(s));
        chk(req, "cancel-finished", int'(cfin_vec), int'(c));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL R11 watchdog expired: got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tx_ready = 1'b1;
        #0.5;
        // R11 reset state
        chk(11, "start in reset", int'(tx_start), 0);
        chk_state(11, 4'b0000, 4'b0000, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        tx_ready = 1'b0;

        for (int i = 0; i < NV; i++) begin
            add_req  = TBL[i].add;
            cxl_req  = TBL[i].cxl;
            tx_ready = TBL[i].rdy;
            tx_done  = TBL[i].done;
            tx_ok    = TBL[i].ok;
            #0.5;
            chk(int'(TBL[i].req), $sformatf("row %0d start", i), int'(tx_start), int'(TBL[i].xs));
            if (TBL[i].xs)
                chk(int'(TBL[i].req), $sformatf("row %0d index", i), int'(tx_start_idx), int'(TBL[i].xi));
            @(posedge clk);
            #0.5;
            chk_state(int'(TBL[i].req), TBL[i].xp, TBL[i].xsent, TBL[i].xc);
            @(negedge clk);
        end
        add_req = '0; cxl_req = '0; tx_ready = 1'b0; tx_done = 1'b0; tx_ok = 1'b0;

        // R3 directed: only b2 and b3 pending, b2 has the lower id
        add_req = 4'b1100;
        @(negedge clk);
        add_req = '0;
        tx_ready = 1'b1;
        #0.5;
        chk(3, "start b2 vs b3", int'(tx_start), 1);
        chk(3, "index b2 vs b3", int'(tx_start_idx), 2);
        @(negedge clk);
        tx_ready = 1'b0;

        // R11 reset in the middle of a transmission
        add_req = 4'b1111;
        rst = 1'b1;
        @(negedge clk);
        add_req = '0;
        rst = 1'b0;
        tx_ready = 1'b1;
        #0.5;
        chk(11, "start after reset", int'(tx_start), 0);
        chk_state(11, 4'b0000, 4'b0000, 4'b0000);
        @(negedge clk);
        tx_ready = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule